// File: doc/BRIEF.md
# Flash Completion Status Poller

This block sits on the host side of a parallel flash bus. Once the host has finished sending a program or erase command sequence, it starts the poller. The poller then reads the target address over and over until the part reports that the operation has finished, or until a poll budget set by the caller runs out.

The poller has two ways to decide that an operation has finished. In polarity mode it looks at data bit 7. For a program it waits until that bit matches bit 7 of the byte that was written. For an erase it waits until that bit reads 1. In toggle mode it looks at data bit 6 and waits until two successive reads return the same value.

Once completion is seen, the rest of the data byte may not yet be valid. The poller therefore stays off the bus for a settle interval of one microsecond, given as a clock count. It then makes one final full-width read and hands that byte back with a single-cycle done pulse.

Top module: `flash_done_poller`

## Requirements
- R1: `start` is taken only in the idle state, and only when `wr_pulses` has reached the last write pulse of the command. That count is at least 4 for a program (`op_erase`=0) and at least 6 for an erase (`op_erase`=1). Otherwise the block stays idle and makes no read.
- R2: Each poll drives `rd_en` high for exactly one cycle, with `rd_addr` equal to the `tgt_addr` latched at start. The read data is sampled in the following cycle, and two reads are never issued in adjacent cycles.
- R3: In polarity mode (`use_toggle`=0) for a program, a poll completes when `rd_data[7]` equals `exp_data[7]`.
- R4: In polarity mode for an erase, a poll completes when `rd_data[7]` is 1.
- R5: In toggle mode (`use_toggle`=1), a poll completes when `rd_data[6]` equals the bit 6 value from the previous poll of the same run. The first poll of a run never completes.
- R6: After the completing poll, no read is made for `CLKS_PER_US` cycles. Then one final read is made, and `done` rises in the cycle after that read with `result` equal to the read byte. Counting cycle 1 as the cycle after start is sampled, with completion at poll N, `done` is high in cycle 2N+`CLKS_PER_US`+2. `result` keeps that byte afterwards.
- R7: If `max_polls` polls finish without completing, `timeout` is high in cycle 2·`max_polls`+1. A `max_polls` of 0 acts as 1. A poll that completes on the last allowed try leads to `done`, not `timeout`.
- R8: `done` and `timeout` are each single-cycle pulses and are never high together. `busy` is high from cycle 1 until the cycle of the pulse.
- R9: A `start` during a run is ignored. The run keeps its address, mode and timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin polling (one-cycle pulse) |
| op_erase | input | 1 | 1 = erase was issued, 0 = program |
| use_toggle | input | 1 | 1 = toggle-bit test, 0 = polarity test |
| exp_data | input | DW | Byte that was programmed |
| tgt_addr | input | AW | Address to poll |
| max_polls | input | CW | Poll budget before timeout |
| wr_pulses | input | 3 | Write pulses issued so far in the command |
| rd_data | input | DW | Read data, valid the cycle after `rd_en` |
| rd_en | output | 1 | Read strobe |
| rd_addr | output | AW | Read address |
| busy | output | 1 | Run in progress |
| done | output | 1 | Completion pulse |
| timeout | output | 1 | Budget exhausted pulse |
| result | output | DW | Byte from the final read |

## Verification
The embedded assertions check several rules on every cycle:
- reads are spaced and the address does not move during a run;
- a rejected start leaves the block idle;
- the final read always follows the settle state;
- the bit 7 test for a program moves straight into settling, and the first toggle sample never does;
- the poll count stays within its budget;
- `done` and `timeout` are exclusive single-cycle pulses.

Only the bench scenarios can show the rest:
- the exact cycle of each pulse for every mix of mode, operation, busy-read count and budget;
- the length of the settle gap;
- the byte returned;
- the ignored mid-run start.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

    localparam int BIT_POLARITY = 7;
    localparam int BIT_TOGGLE   = 6;
    localparam logic [2:0] LAST_WE_PROGRAM = 3'd4;
    localparam logic [2:0] LAST_WE_ERASE   = 3'd6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_COMPARE,
        ST_SETTLE,
        ST_FINAL_READ,
        ST_DONE,
        ST_TIMEOUT
    } poll_state_t;

    typedef struct packed {
        logic erase;
        logic toggle;
        logic exp_msb;
    } job_t;

    function automatic logic start_allowed(input logic erase, input logic [2:0] pulses);
        return erase ? (pulses >= LAST_WE_ERASE) : (pulses >= LAST_WE_PROGRAM);
    endfunction

    function automatic logic polarity_ready(input logic erase, input logic exp_msb,
                                            input logic dq);
        return erase ? dq : (dq == exp_msb);
    endfunction

endpackage

// File: rtl/fp_status_eval.sv
module fp_status_eval
    import fpoll_pkg::*;
(
    input  job_t job,
    input  logic bit_pol,
    input  logic bit_tog,
    input  logic prev_tog,
    input  logic prev_valid,
    output logic complete
);
    always_comb begin
        if (job.toggle)
            complete = prev_valid && (bit_tog == prev_tog);
        else
            complete = polarity_ready(job.erase, job.exp_msb, bit_pol);
    end
endmodule

// File: rtl/fp_settle_timer.sv
module fp_settle_timer #(
    parameter int CYCLES = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int TW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
    localparam logic [TW-1:0] START_VAL = TW'(CYCLES - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= START_VAL;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = run && (cnt == '0);

    AST_SETTLE_LOAD_NOT_EXPIRED: assert property (@(posedge clk) disable iff (rst)
        (load && CYCLES > 1) |=> !expired); // R6
endmodule

// File: rtl/fp_poll_budget.sv
module fp_poll_budget #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          step,
    input  logic [CW-1:0] limit,
    output logic          last
);
    localparam int CW1 = CW + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            lim_q <= CW'(1);
        end else if (clr) begin
            cnt   <= '0;
            lim_q <= (limit == '0) ? CW'(1) : limit;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (CW1'(cnt) + CW1'(1)) >= CW1'(lim_q);

    AST_BUDGET_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= lim_q); // R7
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
    import fpoll_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 16,
    parameter int CW = 8,
    parameter int CLKS_PER_US = 100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          op_erase,
    input  logic          use_toggle,
    input  logic [DW-1:0] exp_data,
    input  logic [AW-1:0] tgt_addr,
    input  logic [CW-1:0] max_polls,
    input  logic [2:0]    wr_pulses,
    input  logic [DW-1:0] rd_data,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          busy,
    output logic          done,
    output logic          timeout,
    output logic [DW-1:0] result
);
    poll_state_t state, state_n;
    job_t        job_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] result_q;
    logic        prev_tog, prev_valid;
    logic        accept, complete, last_poll, settle_done;
    logic        in_compare;

    assign accept     = (state == ST_IDLE) && start && start_allowed(op_erase, wr_pulses);
    assign in_compare = (state == ST_COMPARE);

    fp_status_eval u_eval (
        .job       (job_q),
        .bit_pol   (rd_data[BIT_POLARITY]),
        .bit_tog   (rd_data[BIT_TOGGLE]),
        .prev_tog  (prev_tog),
        .prev_valid(prev_valid),
        .complete  (complete)
    );

    fp_poll_budget #(.CW(CW)) u_budget (
        .clk  (clk),
        .rst  (rst),
        .clr  (accept),
        .step (in_compare),
        .limit(max_polls),
        .last (last_poll)
    );

    fp_settle_timer #(.CYCLES(CLKS_PER_US)) u_settle (
        .clk    (clk),
        .rst    (rst),
        .load   (in_compare && complete),
        .run    (state == ST_SETTLE),
        .expired(settle_done)
    );

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:       if (accept) state_n = ST_READ;
            ST_READ:       state_n = ST_COMPARE;
            ST_COMPARE: begin
                if (complete)       state_n = ST_SETTLE;
                else if (last_poll) state_n = ST_TIMEOUT;
                else                state_n = ST_READ;
            end
            ST_SETTLE:     if (settle_done) state_n = ST_FINAL_READ;
            ST_FINAL_READ: state_n = ST_DONE;
            ST_DONE:       state_n = ST_IDLE;
            ST_TIMEOUT:    state_n = ST_IDLE;
            default:       state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            job_q      <= '0;
            addr_q     <= '0;
            result_q   <= '0;
            prev_tog   <= 1'b0;
            prev_valid <= 1'b0;
        end else begin
            state <= state_n;
            if (accept) begin
                job_q.erase   <= op_erase;
                job_q.toggle  <= use_toggle;
                job_q.exp_msb <= exp_data[BIT_POLARITY];
                addr_q        <= tgt_addr;
                prev_valid    <= 1'b0;
            end
            if (in_compare) begin
                prev_tog   <= rd_data[BIT_TOGGLE];
                prev_valid <= 1'b1;
            end
            if (state == ST_DONE)
                result_q <= rd_data;
        end
    end

    assign rd_en   = (state == ST_READ) || (state == ST_FINAL_READ);
    assign rd_addr = addr_q;
    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_DONE);
    assign timeout = (state == ST_TIMEOUT);
    assign result  = done ? rd_data : result_q;

    AST_GATED_START: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !start_allowed(op_erase, wr_pulses)) |=> (state == ST_IDLE)); // R1
    AST_READ_SPACED: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> !rd_en); // R2
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(rd_addr)); // R9
    AST_PROGRAM_MATCH: assert property (@(posedge clk) disable iff (rst)
        (in_compare && !job_q.toggle && !job_q.erase && rd_data[BIT_POLARITY] == job_q.exp_msb)
        |=> (state == ST_SETTLE)); // R3
    AST_TOGGLE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (in_compare && job_q.toggle && !prev_valid) |=> (state != ST_SETTLE)); // R5
    AST_SETTLE_ORDER: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FINAL_READ) |-> ($past(state) == ST_SETTLE)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(done && timeout)); // R8
endmodule

// File: tb/tb_flash_done_poller.sv
module tb_flash_done_poller;
    localparam int CLK_PERIOD = 10;
    localparam int S  = 4;
    localparam int DW = 8;
    localparam int AW = 16;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, op_erase = 1'b0, use_toggle = 1'b0;
    logic [DW-1:0] exp_data = '0;
    logic [AW-1:0] tgt_addr = '0;
    logic [CW-1:0] max_polls = '0;
    logic [2:0]    wr_pulses = '0;
    logic [DW-1:0] rd_data = '0;
    logic rd_en, busy, done, timeout;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] result;

    int checks = 0, errors = 0, cycles = 0;
    int served = 0;
    int m_busy = 0;
    logic m_erase = 1'b0;
    logic [DW-1:0] m_exp = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_done_poller #(.DW(DW), .AW(AW), .CW(CW), .CLKS_PER_US(S)) dut (
        .clk(clk), .rst(rst), .start(start), .op_erase(op_erase), .use_toggle(use_toggle),
        .exp_data(exp_data), .tgt_addr(tgt_addr), .max_polls(max_polls), .wr_pulses(wr_pulses),
        .rd_data(rd_data), .rd_en(rd_en), .rd_addr(rd_addr), .busy(busy), .done(done),
        .timeout(timeout), .result(result));

    function automatic logic [DW-1:0] ready_byte();
        return m_erase ? 8'hFF : m_exp;
    endfunction

    function automatic logic [DW-1:0] byte_for(int k);
        logic [DW-1:0] b;
        if (k > m_busy) return ready_byte();
        b = DW'(k * 37) ^ 8'h2C;
        b[7] = m_erase ? 1'b0 : ~m_exp[7];
        b[6] = ready_byte() >> 6 ^ 1'(((m_busy - k + 1) & 1));
        return b;
    endfunction

    always @(posedge clk) begin
        if (rd_en) begin
            served = served + 1;
            rd_data <= byte_for(served);
        end
    end

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic ok, input longint act, input longint expv);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic run_case(input logic er, input logic tg, input int b, input int m,
                            input logic [DW-1:0] ex, input logic poke);
        int n, meff, exp_cyc, c, reads, addr_bad;
        logic seen_done, seen_to;
        logic [AW-1:0] a;
        a = AW'(16'h1000 + b * 16'h0111 + m);
        m_erase = er; m_exp = ex; m_busy = b; served = 0;
        @(negedge clk);
        op_erase = er; use_toggle = tg; exp_data = ex; tgt_addr = a;
        max_polls = CW'(m); wr_pulses = 3'd6; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = tg ? b + 2 : b + 1;
        meff = (m == 0) ? 1 : m;
        exp_cyc = (n <= meff) ? 2*n + S + 2 : 2*meff + 1;
        c = 1; reads = 0; addr_bad = 0; seen_done = 0; seen_to = 0;
        while (c < exp_cyc + 20 && !seen_done && !seen_to) begin
            if (c == 3 && poke) begin
                start = 1'b1; tgt_addr = a ^ 16'hFFFF; use_toggle = ~tg; max_polls = 8'd200;
            end else if (c == 4 && poke) begin
                start = 1'b0;
            end
            if (rd_en) begin
                reads++;
                if (rd_addr != a) addr_bad++;
            end
            if (!busy) begin
                check("R8 busy during run", 1'b0, c, 1);
            end
            if (done) seen_done = 1;
            if (timeout) seen_to = 1;
            if (!seen_done && !seen_to) begin
                @(negedge clk);
                c++;
            end
        end
        check(poke ? "R9 mid-run start, address" : "R2 address held", addr_bad == 0, addr_bad, 0);
        if (n <= meff) begin
            check(tg ? "R5 toggle done cycle" : (er ? "R4 erase done cycle" : "R3 program done cycle"),
                  seen_done && c == exp_cyc, seen_done ? c : -1, exp_cyc);
            check("R6 result byte", result == ready_byte(), result, ready_byte());
            check("R2 read count", reads == n + 1, reads, n + 1);
        end else begin
            check("R7 timeout cycle", seen_to && c == exp_cyc, seen_to ? c : -1, exp_cyc);
            check("R7 read count", reads == meff, reads, meff);
        end
        @(negedge clk);
        check("R8 pulse single", !done && !timeout && !busy, {done, timeout, busy}, 0);
        if (n <= meff)
            check("R6 result held", result == ready_byte(), result, ready_byte());
    endtask

    task automatic gated(input logic er, input logic [2:0] p, input logic expect_go);
        @(negedge clk);
        op_erase = er; use_toggle = 1'b0; wr_pulses = p; max_polls = 8'd1; start = 1'b1;
        m_erase = er; m_exp = exp_data; m_busy = 100; served = 0;
        @(negedge clk);
        start = 1'b0;
        check("R1 start gating", busy == expect_go, busy, expect_go);
        repeat (4) @(negedge clk);
        check("R1 no read when rejected", expect_go || served == 0, served, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset busy", !busy, busy, 0);
        check("R8 reset pulses", !done && !timeout, {done, timeout}, 0);
        check("R2 reset rd_en", !rd_en, rd_en, 0);
        rst = 1'b0;
        for (int er = 0; er < 2; er++)
            for (int tg = 0; tg < 2; tg++)
                for (int b = 0; b < 5; b++)
                    for (int m = 0; m < 7; m++)
                        run_case(1'(er), 1'(tg), b, m, DW'(8'h5A ^ (b * 8'h93) ^ (m * 8'h11)), 1'b0);
        run_case(1'b0, 1'b0, 3, 8, 8'hC3, 1'b1);
        run_case(1'b1, 1'b1, 2, 8, 8'h00, 1'b1);
        gated(1'b0, 3'd3, 1'b0);
        gated(1'b1, 3'd5, 1'b0);
        gated(1'b0, 3'd4, 1'b1);
        repeat (6) @(negedge clk);
        gated(1'b1, 3'd6, 1'b1);
        repeat (6) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule